// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor's fetch logic and decides, at each instruction boundary, whether to divert execution into a service routine. Several request lines enter. A mask register screens them and a fixed priority order picks a single winner. The winner's index selects an entry in a small table of routine addresses, and the block then issues a one-cycle program-counter load carrying that address.

When an interrupt is taken, the block pushes the address that follows the interrupted instruction onto a small hardware stack. It pushes the priority level that was active at that moment alongside it. While a routine runs, only strictly more urgent sources may cut in, so nesting is bounded by priority. A return strobe pops the newest entry. The saved address is loaded into the program counter and the earlier priority level comes back into force. The vector table and the mask are written through a plain address/data/write-enable port.

Top module: `irq_vec_ctrl`

## Requirements
- R1: An interrupt is taken only in a cycle where `instr_end`, `gie` and at least one unmasked request are all high. In any other cycle `pc_load` stays low.
- R2: A write to configuration address N_SRC (4 by default) sets the mask register. A set bit i blocks request i completely.
- R3: A write to configuration address i, where i is below N_SRC, sets vector entry i. When an interrupt is taken, `pc_load` pulses for exactly one cycle, starting in the cycle after the boundary, and `pc_next` carries the winner's vector entry during that pulse.
- R4: Source indices are fixed: 0 is trap, 1 is system call, 2 is IO device, 3 is program-initiated. The lowest pending unmasked index wins.
- R5: On a take, the value pushed as the return address is `cur_pc + 1`.
- R6: While level L is in service, requests with index L or above are held off. A request with an index below L is taken as a nested interrupt.
- R7: A high `rti` with a non-empty stack pops the newest entry. It loads `pc_next` with the saved address through a one-cycle `pc_load` pulse and restores the saved priority level. If `rti` and a take fall in the same cycle, `rti` wins.
- R8: A high `rti` while the stack is empty has no effect: there is no `pc_load` and the state does not change.
- R9: If a take would push onto a full stack (STK_DEPTH entries), `overflow` pulses for one cycle. In that case there is no `pc_load` and no push.
- R10: `in_service` is high exactly when the return stack holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the table, the mask, the stack and the level |
| irq_req | input | N_SRC | Request lines, one per source |
| gie | input | 1 | Global interrupt enable |
| instr_end | input | 1 | High in the final cycle of an instruction |
| cur_pc | input | PC_W | Address of the instruction now finishing |
| rti | input | 1 | Return-from-interrupt strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CA_W | 0..N_SRC-1 selects a vector entry; N_SRC selects the mask |
| cfg_wdata | input | PC_W | Write data; the mask uses the low N_SRC bits |
| pc_load | output | 1 | One-cycle request to load `pc_next` into the program counter |
| pc_next | output | PC_W | Routine address or restored return address |
| in_service | output | 1 | At least one interrupt level is active |
| overflow | output | 1 | One-cycle pulse when a take was refused because the stack is full |

## Verification
A single request is tried first with the enable low, then with the boundary strobe low, then masked, and finally with every gate open. Only the last of these may produce a load, which separates the enable gate, the boundary gate and the mask. A multi-bit request word shows whether the lowest index wins. A sequence of requests that each outrank the one in service, together with an equal-or-lower request that arrives during service, separates real nesting from a design that preempts on any request. Unwinding the nest checks the order of the returned addresses, and it also confirms that the lower level is back in force after each pop. A nest deeper than the stack checks the refused push and the overflow pulse, and the unwind that follows shows that the stack was left intact.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // action chosen for the current cycle
   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_TAKE = 2'd1,
      ACT_RET  = 2'd2,
      ACT_OVF  = 2'd3
   } irq_act_e;
endpackage

// File: rtl/irq_pri_sel.sv
module irq_pri_sel #(
   parameter int N_SRC = 4,
   parameter int LVL_W = 3
) (
   input  logic [N_SRC-1:0] req,
   input  logic [N_SRC-1:0] mask,
   output logic             any,
   output logic [LVL_W-1:0] win
);
   logic [N_SRC-1:0] live;

   assign live = req & ~mask;
   assign any  = |live;

   // scan from the highest index down so the lowest index is left standing
   always_comb begin
      win = LVL_W'(N_SRC);
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (live[i]) win = LVL_W'(i);
      end
   end
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs #(
   parameter int N_SRC = 4,
   parameter int PC_W  = 16,
   parameter int CA_W  = 3,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CA_W-1:0]  addr,
   input  logic [PC_W-1:0]  wdata,
   input  logic [LVL_W-1:0] rd_idx,
   output logic [PC_W-1:0]  rd_data,
   output logic [N_SRC-1:0] mask
);
   logic [PC_W-1:0] vec [N_SRC];

   for (genvar g = 0; g < N_SRC; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 vec[g] <= '0;
         else if (we && addr == CA_W'(g))            vec[g] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mask <= '0;
      else if (we && addr == CA_W'(N_SRC))      mask <= wdata[N_SRC-1:0];
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (rd_idx == LVL_W'(i)) rd_data = vec[i];
      end
   end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
   parameter int DEPTH = 4,
   parameter int W     = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top,
   output logic         full,
   output logic         empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int SLOTS = 2 ** IDX_W;

   logic [W-1:0]     mem [SLOTS];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_m1;

   assign cnt_m1 = cnt - 1'b1;
   assign full   = (cnt == CNT_W'(DEPTH));
   assign empty  = (cnt == '0);
   assign top    = mem[cnt_m1[IDX_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
      end else if (push) begin
         mem[cnt[IDX_W-1:0]] <= din;
         cnt <= cnt + 1'b1;
      end else if (pop) begin
         cnt <= cnt_m1;
      end
   end

   // R9
   push_full_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
   // R8
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irq_pkg::*;
#(
   parameter int N_SRC     = 4,
   parameter int PC_W      = 16,
   parameter int STK_DEPTH = 4,
   parameter int CA_W      = $clog2(N_SRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_req,
   input  logic             gie,
   input  logic             instr_end,
   input  logic [PC_W-1:0]  cur_pc,
   input  logic             rti,
   input  logic             cfg_we,
   input  logic [CA_W-1:0]  cfg_addr,
   input  logic [PC_W-1:0]  cfg_wdata,
   output logic             pc_load,
   output logic [PC_W-1:0]  pc_next,
   output logic             in_service,
   output logic             overflow
);
   localparam int LVL_W = $clog2(N_SRC + 1);
   localparam int ENT_W = PC_W + LVL_W;
   localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(N_SRC);

   if (N_SRC < 2)          begin : g_bad_src   $error("N_SRC must be at least 2");   end
   if (STK_DEPTH < 1)      begin : g_bad_depth $error("STK_DEPTH must be positive"); end
   if (CA_W < LVL_W)       begin : g_bad_ca    $error("CA_W too narrow");             end

   logic [N_SRC-1:0] mask;
   logic             any;
   logic [LVL_W-1:0] win;
   logic [PC_W-1:0]  vec_addr;
   logic [ENT_W-1:0] stk_top;
   logic             stk_full, stk_empty;
   logic [LVL_W-1:0] cur_lvl;
   irq_act_e         act;

   irq_pri_sel #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_sel (
      .req(irq_req), .mask(mask), .any(any), .win(win)
   );

   irq_vec_regs #(.N_SRC(N_SRC), .PC_W(PC_W), .CA_W(CA_W), .LVL_W(LVL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .rd_idx(win), .rd_data(vec_addr), .mask(mask)
   );

   irq_ret_stack #(.DEPTH(STK_DEPTH), .W(ENT_W)) u_stk (
      .clk(clk), .rst_n(rst_n),
      .push(act == ACT_TAKE), .pop(act == ACT_RET),
      .din({cur_pc + 1'b1, cur_lvl}),
      .top(stk_top), .full(stk_full), .empty(stk_empty)
   );

   always_comb begin
      act = ACT_NONE;
      if (rti && !stk_empty)                            act = ACT_RET;
      else if (instr_end && gie && any && win < cur_lvl) act = stk_full ? ACT_OVF : ACT_TAKE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_lvl  <= LVL_IDLE;
         pc_load  <= 1'b0;
         pc_next  <= '0;
         overflow <= 1'b0;
      end else begin
         pc_load  <= (act == ACT_TAKE) || (act == ACT_RET);
         overflow <= (act == ACT_OVF);
         case (act)
            ACT_TAKE: begin
               pc_next <= vec_addr;
               cur_lvl <= win;
            end
            ACT_RET: begin
               pc_next <= stk_top[ENT_W-1:LVL_W];
               cur_lvl <= stk_top[LVL_W-1:0];
            end
            default: ;
         endcase
      end
   end

   assign in_service = !stk_empty;

   // R1
   load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> ($past(instr_end) || $past(rti)));
   // R9
   ovf_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> !pc_load);
   // R6
   nest_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !$past(rti)) |-> (cur_lvl < $past(cur_lvl)));
   // R10
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_service |-> (cur_lvl == LVL_IDLE));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
   localparam int N_SRC = 4;
   localparam int PC_W  = 16;
   localparam int DEPTH = 3;
   localparam int CA_W  = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_SRC-1:0] irq_req = '0;
   logic             gie = 1'b0;
   logic             instr_end = 1'b0;
   logic [PC_W-1:0]  cur_pc = '0;
   logic             rti = 1'b0;
   logic             cfg_we = 1'b0;
   logic [CA_W-1:0]  cfg_addr = '0;
   logic [PC_W-1:0]  cfg_wdata = '0;
   logic             pc_load, in_service, overflow;
   logic [PC_W-1:0]  pc_next;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   irq_vec_ctrl #(.N_SRC(N_SRC), .PC_W(PC_W), .STK_DEPTH(DEPTH), .CA_W(CA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .gie(gie), .instr_end(instr_end),
      .cur_pc(cur_pc), .rti(rti), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .pc_load(pc_load), .pc_next(pc_next),
      .in_service(in_service), .overflow(overflow)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input int a, input int d);
      cfg_we = 1'b1; cfg_addr = CA_W'(a); cfg_wdata = PC_W'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // boundary strobe for one cycle; outputs sampled one negedge later
   task automatic boundary(input int pc);
      instr_end = 1'b1; cur_pc = PC_W'(pc);
      @(negedge clk);
      instr_end = 1'b0;
   endtask

   task automatic do_rti();
      rti = 1'b1;
      @(negedge clk);
      rti = 1'b0;
   endtask

   task automatic expect_load(input string tag, input int exp_pc);
      chk(pc_load === 1'b1, {tag, " load"}, int'(pc_load), 1);
      chk(pc_next === PC_W'(exp_pc), {tag, " addr"}, int'(pc_next), exp_pc);
   endtask

   task automatic t_reset();
      // R1 R10: quiet after reset
      chk(pc_load === 1'b0, "R1 reset load", int'(pc_load), 0);
      chk(in_service === 1'b0, "R10 reset service", int'(in_service), 0);
      chk(overflow === 1'b0, "R9 reset ovf", int'(overflow), 0);
   endtask

   task automatic t_gates();
      irq_req = 4'b0100;
      gie = 1'b0;
      boundary(16'h20);
      chk(pc_load === 1'b0, "R1 gie low", int'(pc_load), 0);
      gie = 1'b1;
      @(negedge clk);
      chk(pc_load === 1'b0, "R1 no boundary", int'(pc_load), 0);
      cfg_wr(4, 4'b0100);
      boundary(16'h20);
      chk(pc_load === 1'b0, "R2 masked", int'(pc_load), 0);
      chk(in_service === 1'b0, "R2 masked service", int'(in_service), 0);
      cfg_wr(4, 0);
      boundary(16'h20);
      expect_load("R3 vector", 16'h1200);
      chk(in_service === 1'b1, "R10 active", int'(in_service), 1);
      irq_req = '0;
      @(negedge clk);
      chk(pc_load === 1'b0, "R3 single pulse", int'(pc_load), 0);
      do_rti();
      expect_load("R5 R7 return", 16'h21);
      chk(in_service === 1'b0, "R10 idle again", int'(in_service), 0);
      do_rti();
      chk(pc_load === 1'b0, "R8 empty rti", int'(pc_load), 0);
   endtask

   task automatic t_nest();
      irq_req = 4'b1110;
      boundary(16'h40);
      expect_load("R4 lowest wins", 16'h1100);
      irq_req = 4'b1100;
      boundary(16'h44);
      chk(pc_load === 1'b0, "R6 lower held", int'(pc_load), 0);
      irq_req = 4'b1110;
      boundary(16'h46);
      chk(pc_load === 1'b0, "R6 equal held", int'(pc_load), 0);
      irq_req = 4'b1101;
      boundary(16'h50);
      expect_load("R6 nest", 16'h1000);
      irq_req = 4'b1100;
      do_rti();
      expect_load("R7 inner return", 16'h51);
      boundary(16'h52);
      chk(pc_load === 1'b0, "R7 level restored", int'(pc_load), 0);
      // R7: rti and a take in the same cycle, rti wins
      irq_req = 4'b1101;
      rti = 1'b1; instr_end = 1'b1; cur_pc = 16'h54;
      @(negedge clk);
      rti = 1'b0; instr_end = 1'b0;
      expect_load("R7 rti wins", 16'h41);
      chk(in_service === 1'b0, "R7 stack empty", int'(in_service), 0);
      irq_req = 4'b1100;
      boundary(16'h60);
      expect_load("R4 R7 resume lower", 16'h1200);
      irq_req = '0;
      do_rti();
      expect_load("R5 outer return", 16'h61);
   endtask

   task automatic t_ovf();
      irq_req = 4'b1000; boundary(16'h70); expect_load("R9 lvl3", 16'h1300);
      irq_req = 4'b1100; boundary(16'h80); expect_load("R9 lvl2", 16'h1200);
      irq_req = 4'b1110; boundary(16'h90); expect_load("R9 lvl1", 16'h1100);
      irq_req = 4'b1111; boundary(16'hA0);
      chk(overflow === 1'b1, "R9 ovf pulse", int'(overflow), 1);
      chk(pc_load === 1'b0, "R9 no load", int'(pc_load), 0);
      irq_req = '0;
      @(negedge clk);
      chk(overflow === 1'b0, "R9 ovf one cycle", int'(overflow), 0);
      do_rti(); expect_load("R9 pop1", 16'h91);
      do_rti(); expect_load("R9 pop2", 16'h81);
      do_rti(); expect_load("R9 pop3", 16'h71);
      chk(in_service === 1'b0, "R10 unwound", int'(in_service), 0);
   endtask

   initial begin
      fork
         begin
            repeat (50000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      join_none
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int i = 0; i < N_SRC; i++) cfg_wr(i, 16'h1000 + i * 16'h100);
      t_gates();
      t_nest();
      t_ovf();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule